// File: doc/BRIEF.md
# Bidirectional 8-bit Timer with Buffered Compare

The block is an 8-bit timer/counter driven by a selectable timer tick. The tick is either every clock, an externally prescaled pulse, or a chosen edge of an external pin that is first passed through a two-flop synchronizer. On every tick the counter steps according to one of four modes. It can run freely upward, clear at the compare value, or sweep up and down with the limit at the all-ones value or at the compare value.

A compare unit checks the counter against the active compare value on every tick. A match sets a compare flag and drives a waveform pin. The compare value written by software lands in a holding buffer. It reaches the active compare register only on a tick taken at the bottom or the top of the count, so that a period already under way is never cut short. An overflow flag marks each tick taken at the limit in the upward direction. Both flags stay set until software clears them and can serve as interrupt requests.

Software reaches the block through a simple register port with four addresses. Address 0 holds the count, address 1 the compare buffer, address 2 the control register and address 3 the flags. Writes take effect on the clock edge. Reads are combinational.

Top module: `tc8_unit`

## Requirements
- R1: After reset the count, the compare buffer, the active compare value, the control register, both flags and the waveform pin are all zero.
- R2: The control field cs = bits [2:0] of address 2 selects the tick source. Value 001 gives a tick on every clock and 010 follows the presc_tick input. Value 111 gives a tick on a rising edge of ext_pin and 110 on a falling edge, each detected after a two-flop synchronizer. Every other value, 000 included, stops the counter.
- R3: In mode 00, where mode = bits [4:3] of address 2, the counter increments on each tick. A tick at 0xFF wraps it to 0x00 and sets the overflow flag.
- R4: In mode 01 the limit is the active compare value. A tick taken with the count at or above that limit loads 0x00 and sets the overflow flag.
- R5: Modes 10 and 11 count up to the limit and down to 0x00, reversing at each end. The limit is 0xFF in mode 10 and the active compare value in mode 11. The overflow flag is set by the tick taken at the limit while counting up. With a limit of zero the count stays at 0x00.
- R6: A write to address 1 updates the compare buffer, which reads back at address 1. The active compare value copies the buffer only on a tick taken when the count is 0x00 or at the limit.
- R7: A tick whose pre-tick count equals the active compare value sets the compare flag, unless it is blocked by R10.
- R8: On a compare match the waveform pin toggles in modes 00 and 01. In modes 10 and 11 it goes to 1 on a match while counting up and to 0 on a match while counting down.
- R9: Address 3 reads back the compare flag in bit 0 and the overflow flag in bit 1. Writing 1 to a bit clears that flag, but a flag-setting event in the same cycle wins over the clear.
- R10: A write to address 0 loads the count and cancels any tick in that cycle. The first tick after it makes no compare match.
- R11: The control register at address 2 reads back the written cs and mode fields, with bits above 4 reading as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| presc_tick | input | 1 | Prescaled tick pulse from outside |
| ext_pin | input | 1 | External count pin (asynchronous) |
| cmp_out | output | 1 | Compare waveform pin |
| cmp_flag | output | 1 | Compare match flag / request |
| ovf_flag | output | 1 | Overflow flag / request |

## Verification
The bench aims at several corner cases:
- The wrap from 0xFF, which a broken design would miss or flag one tick late.
- A compare write made mid-period, which must not move the match until the next bottom or top; an eager design would match early.
- The reversal points of the up/down sweep, including a zero limit, where a design that stepped past the end would leave the 0x00..limit range.
- The one-tick match suppression after a count write, and the synchronized edge counting on the external pin, where a design without it would count extra or missing edges.

A per-clock behavioural model catches any cycle where the count, the flags or the pin drift from the rules.

// File: rtl/tc8_pkg.sv
package tc8_pkg;
    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    localparam logic [1:0] MODE_FREE     = 2'b00;
    localparam logic [1:0] MODE_CLRCMP   = 2'b01;
    localparam logic [1:0] MODE_DUAL_MAX = 2'b10;
    localparam logic [1:0] MODE_DUAL_CMP = 2'b11;

    localparam logic [2:0] CS_STOP     = 3'b000;
    localparam logic [2:0] CS_SYS      = 3'b001;
    localparam logic [2:0] CS_PRESC    = 3'b010;
    localparam logic [2:0] CS_EXT_FALL = 3'b110;
    localparam logic [2:0] CS_EXT_RISE = 3'b111;

    typedef struct packed {
        logic [2:0] cs;
        logic [1:0] mode;
        logic       cmp_f;
        logic       ovf_f;
    } ctl_regs_t;
endpackage

// File: rtl/tc8_tick_sel.sv
module tc8_tick_sel
    import tc8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    input  logic       presc_tick,
    input  logic       ext_pin,
    output logic       tick
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t r_d, r_q;
    logic  edge_rise, edge_fall;

    always_comb begin
        r_d.s1   = ext_pin;
        r_d.s2   = r_q.s1;
        r_d.prev = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign edge_rise = r_q.s2 & ~r_q.prev;
    assign edge_fall = ~r_q.s2 & r_q.prev;

    always_comb begin
        case (clk_sel)
            CS_SYS:      tick = 1'b1;
            CS_PRESC:    tick = presc_tick;
            CS_EXT_FALL: tick = edge_fall;
            CS_EXT_RISE: tick = edge_rise;
            default:     tick = 1'b0;
        endcase
    end

    // R2
    ext_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == CS_EXT_RISE && tick) |-> ($past(r_q.s1) && !r_q.prev));
endmodule

// File: rtl/tc8_counter.sv
module tc8_counter
    import tc8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         dual,
    input  logic         free_mode,
    input  logic [W-1:0] top_val,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         dir_down,
    output logic         step,
    output logic         at_top,
    output logic         at_bottom,
    output logic         ovf_evt
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] MAXV = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } cnt_st_t;

    cnt_st_t c_d, c_q;

    assign cnt       = c_q.cnt;
    assign dir_down  = dual & c_q.down;
    assign step      = tick & ~load_en;
    assign at_top    = (c_q.cnt >= top_val);
    assign at_bottom = (c_q.cnt == ZERO);
    assign ovf_evt   = step & at_top & ~dir_down;

    always_comb begin
        c_d = c_q;
        if (load_en) begin
            c_d.cnt = load_val;
        end else if (tick) begin
            if (!dual) begin
                c_d.cnt = at_top ? ZERO : c_q.cnt + ONE;
            end else if (!dir_down) begin
                if (at_top) begin
                    c_d.down = 1'b1;
                    c_d.cnt  = at_bottom ? ZERO : c_q.cnt - ONE;
                end else begin
                    c_d.cnt = c_q.cnt + ONE;
                end
            end else begin
                if (at_bottom) begin
                    c_d.down = 1'b0;
                    c_d.cnt  = (top_val == ZERO) ? ZERO : ONE;
                end else begin
                    c_d.cnt = c_q.cnt - ONE;
                end
            end
        end
        if (!dual) c_d.down = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(cnt));

    // R3
    free_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_mode && step && cnt != MAXV) |=> (cnt == $past(cnt) + ONE));

    // R3
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_mode && step && cnt == MAXV) |=> (cnt == ZERO));

    // R5
    bottom_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual && step && dir_down && at_bottom && top_val != ZERO) |=> (cnt == ONE && !dir_down));
endmodule

// File: rtl/tc8_compare.sv
module tc8_compare
    import tc8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buf_we,
    input  logic [W-1:0] buf_wdata,
    input  logic         step,
    input  logic         load_en,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [W-1:0] cnt,
    input  logic         dual,
    input  logic         dir_down,
    output logic [W-1:0] act_cmp,
    output logic [W-1:0] buf_cmp,
    output logic         match_evt,
    output logic         pin
);
    typedef struct packed {
        logic [W-1:0] act;
        logic [W-1:0] hold;
        logic         block;
        logic         pin;
    } cmp_st_t;

    cmp_st_t m_d, m_q;

    assign act_cmp   = m_q.act;
    assign buf_cmp   = m_q.hold;
    assign pin       = m_q.pin;
    assign match_evt = step & (cnt == m_q.act) & ~m_q.block;

    always_comb begin
        m_d = m_q;
        if (buf_we) m_d.hold = buf_wdata;
        if (step && (at_top || at_bottom)) m_d.act = m_q.hold;
        if (load_en)   m_d.block = 1'b1;
        else if (step) m_d.block = 1'b0;
        if (match_evt) begin
            if (dual) m_d.pin = ~dir_down;
            else      m_d.pin = ~m_q.pin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step) |=> $stable(act_cmp));

    // R8
    pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !dual) |=> (pin != $past(pin)));

    // R8
    pin_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_evt) |=> $stable(pin));
endmodule

// File: rtl/tc8_unit.sv
module tc8_unit
    import tc8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         presc_tick,
    input  logic         ext_pin,
    output logic         cmp_out,
    output logic         cmp_flag,
    output logic         ovf_flag
);
    localparam logic [W-1:0] MAXV = '1;

    ctl_regs_t    r_d, r_q;
    logic         tick, dual, free_mode, step, at_top, at_bottom, ovf_evt, dir_down;
    logic         match_evt, pin;
    logic         wr_cnt, wr_cmp, wr_ctrl, wr_flag;
    logic [W-1:0] cnt, act_cmp, buf_cmp, top_val;

    assign wr_cnt  = wr_en && (wr_addr == ADDR_CNT);
    assign wr_cmp  = wr_en && (wr_addr == ADDR_CMP);
    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_flag = wr_en && (wr_addr == ADDR_FLAG);

    assign dual      = r_q.mode[1];
    assign free_mode = (r_q.mode == MODE_FREE);
    assign top_val   = (r_q.mode == MODE_CLRCMP || r_q.mode == MODE_DUAL_CMP) ? act_cmp : MAXV;

    tc8_tick_sel u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_sel    (r_q.cs),
        .presc_tick (presc_tick),
        .ext_pin    (ext_pin),
        .tick       (tick)
    );

    tc8_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .dual      (dual),
        .free_mode (free_mode),
        .top_val   (top_val),
        .load_en   (wr_cnt),
        .load_val  (wr_data),
        .cnt       (cnt),
        .dir_down  (dir_down),
        .step      (step),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .ovf_evt   (ovf_evt)
    );

    tc8_compare #(.W(W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_we    (wr_cmp),
        .buf_wdata (wr_data),
        .step      (step),
        .load_en   (wr_cnt),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .cnt       (cnt),
        .dual      (dual),
        .dir_down  (dir_down),
        .act_cmp   (act_cmp),
        .buf_cmp   (buf_cmp),
        .match_evt (match_evt),
        .pin       (pin)
    );

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.cs   = wr_data[2:0];
            r_d.mode = wr_data[4:3];
        end
        r_d.cmp_f = match_evt | (r_q.cmp_f & ~(wr_flag & wr_data[0]));
        r_d.ovf_f = ovf_evt   | (r_q.ovf_f & ~(wr_flag & wr_data[1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (rd_addr)
            ADDR_CNT:  rd_data = cnt;
            ADDR_CMP:  rd_data = buf_cmp;
            ADDR_CTRL: rd_data = {{(W-5){1'b0}}, r_q.mode, r_q.cs};
            default:   rd_data = {{(W-2){1'b0}}, r_q.ovf_f, r_q.cmp_f};
        endcase
    end

    assign cmp_out  = pin;
    assign cmp_flag = r_q.cmp_f;
    assign ovf_flag = r_q.ovf_f;

    // R7
    match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> cmp_flag);

    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && wr_data[1] && !ovf_evt) |=> !ovf_flag);

    // R10
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wr_data)));

    // R11
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (rd_addr != ADDR_CTRL || rd_data == {{(W-5){1'b0}}, $past(wr_data[4:0])}));
endmodule

// File: tb/tc8_unit_test.sv
`timescale 1ns/1ps
module tc8_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       presc_tick = 1'b0;
    logic       ext_pin = 1'b0;
    logic       cmp_out, cmp_flag, ovf_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tc8_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .presc_tick(presc_tick), .ext_pin(ext_pin),
        .cmp_out(cmp_out), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
    );

    // behavioural reference
    int m_cnt, m_down, m_act, m_buf, m_blk, m_pin, m_cf, m_of, m_cs, m_mode, m_s1, m_s2, m_pv;
    int tk, stp, wc, dual, top, dn, attop, atbot, mt, ov, nc, nd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_down = 0; m_act = 0; m_buf = 0; m_blk = 0; m_pin = 0;
            m_cf = 0; m_of = 0; m_cs = 0; m_mode = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
        end else begin
            case (m_cs)
                1: tk = 1;
                2: tk = int'(presc_tick);
                6: tk = (m_s2 == 0 && m_pv == 1) ? 1 : 0;
                7: tk = (m_s2 == 1 && m_pv == 0) ? 1 : 0;
                default: tk = 0;
            endcase
            wc    = (wr_en && wr_addr == 2'd0) ? 1 : 0;
            stp   = (tk != 0 && wc == 0) ? 1 : 0;
            dual  = (m_mode >= 2) ? 1 : 0;
            top   = (m_mode == 1 || m_mode == 3) ? m_act : 255;
            dn    = dual ? m_down : 0;
            attop = (m_cnt >= top) ? 1 : 0;
            atbot = (m_cnt == 0) ? 1 : 0;
            mt    = (stp && m_cnt == m_act && m_blk == 0) ? 1 : 0;
            ov    = (stp && attop && dn == 0) ? 1 : 0;
            nc = m_cnt; nd = dn;
            if (wc) nc = int'(wr_data);
            else if (stp) begin
                if (!dual) nc = attop ? 0 : m_cnt + 1;
                else if (dn == 0) begin
                    if (attop) begin nd = 1; nc = atbot ? 0 : m_cnt - 1; end
                    else nc = m_cnt + 1;
                end else begin
                    if (atbot) begin nd = 0; nc = (top == 0) ? 0 : 1; end
                    else nc = m_cnt - 1;
                end
            end
            if (!dual) nd = 0;
            if (mt) m_pin = dual ? (dn ? 0 : 1) : (1 - m_pin);
            if (stp && (attop || atbot)) m_act = m_buf;
            if (wr_en && wr_addr == 2'd1) m_buf = int'(wr_data);
            if (wc) m_blk = 1; else if (stp) m_blk = 0;
            m_cf = (mt || (m_cf && !(wr_en && wr_addr == 2'd3 && wr_data[0]))) ? 1 : 0;
            m_of = (ov || (m_of && !(wr_en && wr_addr == 2'd3 && wr_data[1]))) ? 1 : 0;
            if (wr_en && wr_addr == 2'd2) begin
                m_cs = int'(wr_data[2:0]);
                m_mode = int'(wr_data[4:3]);
            end
            m_pv = m_s2; m_s2 = m_s1; m_s1 = int'(ext_pin);
            m_cnt = nc; m_down = nd;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison, away from the edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            if (rd_addr == 2'd0) chk("R3 R4 R5 per-clock count", int'(rd_data), m_cnt);
            chk("R7 per-clock cmp_flag", int'(cmp_flag), m_cf);
            chk("R9 per-clock ovf_flag", int'(ovf_flag), m_of);
            chk("R8 per-clock cmp_out", int'(cmp_out), m_pin);
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
        rd_addr = a;
        #1;
        chk(tag, int'(rd_data), exp);
        rd_addr = 2'd0;
    endtask

    task automatic sweep(input int n, output int mx, output int mn, output int jumps);
        int prev;
        mx = 0; mn = 255; jumps = 0; prev = int'(rd_data);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (int'(rd_data) > mx) mx = int'(rd_data);
            if (int'(rd_data) < mn) mn = int'(rd_data);
            if (int'(rd_data) - prev > 1 || prev - int'(rd_data) > 1) jumps++;
            prev = int'(rd_data);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int mx, mn, jumps;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1
        rd_chk("R1 count", 2'd0, 0);
        rd_chk("R1 buffer", 2'd1, 0);
        rd_chk("R1 control", 2'd2, 0);
        rd_chk("R1 flags", 2'd3, 0);
        chk("R1 pin", int'(cmp_out), 0);
        // R11
        bus_wr(2'd2, 8'hFA);
        rd_chk("R11 control readback", 2'd2, 8'h1A);
        bus_wr(2'd2, 8'h00);
        // R2 stopped
        idle(5);
        rd_chk("R2 stopped count", 2'd0, 0);
        // R3 wrap
        bus_wr(2'd0, 8'hFC);
        bus_wr(2'd2, 8'h01);
        idle(4);
        rd_chk("R3 wrap count", 2'd0, 0);
        chk("R3 overflow set", int'(ovf_flag), 1);
        // R9 clear overflow, R7 match at zero, R8 toggle
        bus_wr(2'd3, 8'h02);
        chk("R9 overflow cleared", int'(ovf_flag), 0);
        chk("R7 match at zero", int'(cmp_flag), 1);
        chk("R8 pin toggled", int'(cmp_out), 1);
        rd_chk("R9 flag readback", 2'd3, 1);
        // R6 buffered compare
        bus_wr(2'd1, 8'h40);
        rd_chk("R6 buffer readback", 2'd1, 8'h40);
        bus_wr(2'd3, 8'h01);
        idle(80);
        chk("R6 no early match", int'(cmp_flag), 0);
        idle(256);
        chk("R6 match after reload", int'(cmp_flag), 1);
        // R4 clear on compare
        bus_wr(2'd1, 8'h10);
        bus_wr(2'd2, 8'h09);
        idle(300);
        bus_wr(2'd3, 8'h03);
        sweep(100, mx, mn, jumps);
        chk("R4 limit reached", mx, 8'h10);
        chk("R4 overflow set", int'(ovf_flag), 1);
        // R5 dual slope full range
        bus_wr(2'd2, 8'h11);
        idle(600);
        sweep(600, mx, mn, jumps);
        chk("R5 top 0xFF", mx, 255);
        chk("R5 bottom 0x00", mn, 0);
        chk("R5 unit steps", jumps, 0);
        // R5 dual slope compare limit
        bus_wr(2'd1, 8'h20);
        bus_wr(2'd2, 8'h19);
        idle(600);
        sweep(200, mx, mn, jumps);
        chk("R5 compare limit", mx, 8'h20);
        chk("R5 compare unit steps", jumps, 0);
        // R5 zero limit
        bus_wr(2'd1, 8'h00);
        idle(600);
        rd_chk("R5 zero limit count", 2'd0, 0);
        // R10 blocked match
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd1, 8'h30);
        bus_wr(2'd2, 8'h01);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd3, 8'h03);
        bus_wr(2'd0, 8'h30);
        bus_wr(2'd2, 8'h01);
        idle(3);
        chk("R10 match suppressed", int'(cmp_flag), 0);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd0, 8'h2F);
        bus_wr(2'd2, 8'h01);
        idle(3);
        chk("R10 match after one tick", int'(cmp_flag), 1);
        // R2 external and prescaled sources
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd2, 8'h07);
        for (int i = 0; i < 3; i++) begin
            ext_pin = 1'b1; idle(4); ext_pin = 1'b0; idle(4);
        end
        rd_chk("R2 rising edges", 2'd0, 3);
        bus_wr(2'd2, 8'h06);
        for (int i = 0; i < 2; i++) begin
            ext_pin = 1'b1; idle(4); ext_pin = 1'b0; idle(4);
        end
        rd_chk("R2 falling edges", 2'd0, 5);
        bus_wr(2'd2, 8'h02);
        for (int i = 0; i < 4; i++) begin
            presc_tick = 1'b1; idle(1); presc_tick = 1'b0; idle(2);
        end
        rd_chk("R2 prescaled ticks", 2'd0, 9);
        bus_wr(2'd2, 8'h03);
        presc_tick = 1'b1; idle(10); presc_tick = 1'b0;
        rd_chk("R2 unused code stops", 2'd0, 9);
        idle(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule